// File: doc/BRIEF.md
# Random Byte Source Register Interface

This block puts a random bit stream behind three byte-wide registers on a simple memory-mapped bus. A control register carries a fixed, read-only flag that reports the generator is fitted, plus one writable enable bit. A status register shows whether a fresh random byte is waiting. A data register hands that byte out. Reading the data register consumes the byte.

Random bits arrive on a valid/ready stream. The block accepts bits only while enabled and packs every eight accepted bits into a byte. A finished byte moves into a holding register and raises the data-present flag. While a byte is waiting unread, the block keeps accepting the first seven bits of the next byte. It applies back-pressure by holding `ent_ready` low only when the eighth bit would overwrite the byte that is still waiting. Any upstream source may drive the stream, as long as it holds `ent_valid` and `ent_bit` steady until it sees `ent_ready` high at a clock edge. Only the bus interface clears the stall.

Software turns the generator on by writing the enable bit, and reads the control register back to confirm the change. It then polls the status register and reads the data register once per byte.

Top module: `rng_regif`

## Requirements
- R1: Register map by `bus_addr`: 0 is the control register, 1 is the status register, 2 is the data register, and 3 reads as 0x00. A read strobe in one cycle loads `bus_rdata` at that clock edge. `bus_rdata` holds its value until the next read strobe.
- R2: Bit 6 of the control register always reads 1. Writes do not change it. Bits 7 and 5..1 of the control register always read 0.
- R3: Bit 0 of the control register is the enable bit, and `bus_wdata[0]` writes it. A control read issued in the cycle after the write returns the new value.
- R4: Bit 0 of the status register reads 1 while a byte waits in the data register. Bits 7..1 of the status register read 0.
- R5: While the block is disabled, `ent_ready` is 0 and the data-present flag is 0. A write that clears the enable bit discards any partly assembled byte, including a bit handshaked in the same cycle. The same write also clears a waiting byte's present flag.
- R6: Eight accepted bits form one byte. The first accepted bit lands in bit 7 and the last in bit 0. The data-present flag sets at the edge that accepts the eighth bit, and a data read then returns that byte.
- R7: A read of the data register clears the data-present flag.
- R8: While a byte waits, `ent_ready` stays 1 for the next seven bits. `ent_ready` drops to 0 before the eighth bit and rises again after the data read.
- R9: A data read can fall in the same cycle as the eighth bit while no byte is waiting. In that case the read returns the previous holding value and the data-present flag ends up set.
- R10: After reset the block is disabled, no data is present, `bus_rdata` is 0x00 and `ent_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ent_valid | input | 1 | Random bit valid |
| ent_bit | input | 1 | Random bit |
| ent_ready | output | 1 | Block accepts a random bit |

## Verification
Two events can coincide in one cycle: the eighth bit completing a byte, and a bus access that either consumes the data register or clears the enable bit. The bench drives the final bit handshake and the bus strobe on the same clock edge. In the read case it expects the old holding value on `bus_rdata`, a set status bit, and the new byte on the next data read. In the disable case it expects the status to stay clear after re-enabling, and a freshly sent byte to read back with nothing left over from the partial byte.

// File: rtl/rng_regif_pkg.sv
package rng_regif_pkg;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 2;
  localparam int CNT_W       = $clog2(BYTE_W);
  localparam int PRESENT_POS = 6;
  localparam int ENABLE_POS  = 0;
  localparam int READY_POS   = 0;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rng_collector.sv
module rng_collector
  import rng_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              flush,
  input  logic              hold_full,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              in_ready,
  output logic              word_done,
  output logic [BYTE_W-1:0] word
);
  logic [BYTE_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_bit;
  logic              accept;

  assign last_bit  = (cnt_q == CNT_W'(BYTE_W-1));
  // stall only the bit that would overwrite a waiting byte
  assign in_ready  = enable && !(hold_full && last_bit);
  assign accept    = in_valid && in_ready && !flush;
  assign word_done = accept && last_bit;
  assign word      = {shreg_q[BYTE_W-2:0], in_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (flush) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (accept) begin
      shreg_q <= word;
      cnt_q   <= last_bit ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rng_regfile.sv
module rng_regfile
  import rng_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              word_done,
  input  logic [BYTE_W-1:0] word,
  output logic              en,
  output logic              present,
  output logic              disable_now,
  output logic [BYTE_W-1:0] rdata
);
  logic              en_q, present_q;
  logic [BYTE_W-1:0] hold_q, rdata_q, rmux;
  logic              wr_ctrl, rd_data;
  logic              unused_wdata_bits;

  assign unused_wdata_bits = ^wdata[BYTE_W-1:1];
  assign wr_ctrl     = wr && (reg_sel_e'(addr) == SEL_CTRL);
  assign rd_data     = rd && (reg_sel_e'(addr) == SEL_DATA);
  assign disable_now = wr_ctrl && !wdata[ENABLE_POS];

  always_comb begin
    rmux = '0;
    case (reg_sel_e'(addr))
      SEL_CTRL: begin
        rmux[PRESENT_POS] = 1'b1;
        rmux[ENABLE_POS]  = en_q;
      end
      SEL_STAT: rmux[READY_POS] = present_q;
      SEL_DATA: rmux = hold_q;
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      present_q <= 1'b0;
      hold_q    <= '0;
      rdata_q   <= '0;
    end else begin
      if (wr_ctrl) en_q <= wdata[ENABLE_POS];
      if (disable_now)      present_q <= 1'b0;
      else if (word_done)   present_q <= 1'b1;
      else if (rd_data)     present_q <= 1'b0;
      if (word_done && !disable_now) hold_q <= word;
      if (rd) rdata_q <= rmux;
    end
  end

  assign en      = en_q;
  assign present = present_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/rng_regif.sv
module rng_regif
  import rng_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              ent_valid,
  input  logic              ent_bit,
  output logic              ent_ready
);
  logic              en_w, present_w, disable_w, done_w;
  logic [BYTE_W-1:0] word_w;

  rng_collector u_collect (
    .clk(clk), .rst_n(rst_n), .enable(en_w), .flush(disable_w || !en_w),
    .hold_full(present_w), .in_valid(ent_valid), .in_bit(ent_bit),
    .in_ready(ent_ready), .word_done(done_w), .word(word_w)
  );

  rng_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .word_done(done_w), .word(word_w), .en(en_w),
    .present(present_w), .disable_now(disable_w), .rdata(bus_rdata)
  );
endmodule

// File: rtl/rng_regif_chk.sv
module rng_regif_chk
  import rng_regif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              ent_ready,
  input logic              en_w,
  input logic              present_w
);
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  p_presence_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0) |=> (bus_rdata[7:1] == 7'b0100000));
  p_enable_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> (en_w == $past(bus_wdata[0])));
  p_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1) |=> (bus_rdata == {7'b0, $past(present_w)}));
  p_idle_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_w |-> (!ent_ready && !present_w));
  p_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd2 && present_w) |=> !present_w);
  p_ready_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w && !present_w) |-> ent_ready);
endmodule

bind rng_regif rng_regif_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ent_ready(ent_ready), .en_w(en_w), .present_w(present_w)
);

// File: tb/test_rng_regif.sv
`timescale 1ns/1ps
module test_rng_regif;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ent_valid = 1'b0, ent_bit = 1'b0;
  logic       ent_ready;
  int         n_cmp = 0, n_bad = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  rng_regif i_rng_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ent_valid(ent_valid), .ent_bit(ent_bit), .ent_ready(ent_ready)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ent_valid = 1'b1; ent_bit = b;
    @(negedge clk); ent_valid = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 rdata", bus_rdata, 8'h00);
    check("R10 ready", {7'b0, ent_ready}, 8'h00);
    rst_n = 1'b1;
    rd_reg(2'd0, rv); check("R10 ctrl", rv, 8'h40);
    rd_reg(2'd1, rv); check("R10 status", rv, 8'h00);
    // R1 unused address and hold
    rd_reg(2'd3, rv); check("R1 addr3", rv, 8'h00);
    repeat (3) @(negedge clk);
    check("R1 hold", bus_rdata, 8'h00);
    // R2 R3 control writes
    wr_reg(2'd0, 8'hFF); rd_reg(2'd0, rv); check("R3 enable on", rv, 8'h41);
    wr_reg(2'd0, 8'h00); rd_reg(2'd0, rv); check("R2 presence kept", rv, 8'h40);
    wr_reg(2'd0, 8'hBE); rd_reg(2'd0, rv); check("R2 only bit0", rv, 8'h40);
    // R5 disabled: no acceptance
    @(negedge clk); check("R5 ready low", {7'b0, ent_ready}, 8'h00);
    send_bits(8'hFF, 8);
    wr_reg(2'd0, 8'h01);
    rd_reg(2'd1, rv); check("R5 nothing collected", rv, 8'h00);
    @(negedge clk); check("R8 ready idle", {7'b0, ent_ready}, 8'h01);
    // R6 R4 R7 exhaustive byte sweep
    for (int v = 0; v < 256; v++) begin
      send_bits(8'(v), 8);
      rd_reg(2'd1, rv); check("R4 present set", rv, 8'h01);
      rd_reg(2'd2, rv); check("R6 byte", rv, 8'(v));
      rd_reg(2'd1, rv); check("R7 consumed", rv, 8'h00);
    end
    // R5 partial byte discarded on disable
    send_bits(8'hFF, 5);
    wr_reg(2'd0, 8'h00); wr_reg(2'd0, 8'h01);
    send_bits(8'hA5, 8);
    rd_reg(2'd2, rv); check("R5 partial dropped", rv, 8'hA5);
    // R5 disable clears a waiting byte
    send_bits(8'h11, 8);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd1, rv); check("R5 present cleared", rv, 8'h00);
    wr_reg(2'd0, 8'h01);
    rd_reg(2'd1, rv); check("R5 stays clear", rv, 8'h00);
    // R8 back-pressure
    send_bits(8'h3C, 8);
    send_bits(8'h81, 7);
    @(negedge clk); check("R8 stall", {7'b0, ent_ready}, 8'h00);
    ent_valid = 1'b1; ent_bit = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 still stalled", {7'b0, ent_ready}, 8'h00);
    rd_reg(2'd2, rv); check("R8 held byte", rv, 8'h3C);
    @(negedge clk); ent_valid = 1'b0;
    rd_reg(2'd1, rv); check("R8 resumed", rv, 8'h01);
    rd_reg(2'd2, rv); check("R8 next byte", rv, 8'h81);
    // R9 read collides with eighth bit
    send_bits(8'h5A, 7);
    @(negedge clk); ent_valid = 1'b1; ent_bit = 1'b0; bus_addr = 2'd2; bus_rd = 1'b1;
    @(negedge clk); ent_valid = 1'b0; bus_rd = 1'b0;
    check("R9 old value", bus_rdata, 8'h81);
    rd_reg(2'd1, rv); check("R9 present set", rv, 8'h01);
    rd_reg(2'd2, rv); check("R9 new byte", rv, 8'h5A);
    // R5 disable collides with eighth bit
    send_bits(8'hFF, 7);
    @(negedge clk); ent_valid = 1'b1; ent_bit = 1'b1;
    bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = 8'h00;
    @(negedge clk); ent_valid = 1'b0; bus_wr = 1'b0;
    wr_reg(2'd0, 8'h01);
    rd_reg(2'd1, rv); check("R5 collide no byte", rv, 8'h00);
    send_bits(8'hC3, 8);
    rd_reg(2'd2, rv); check("R5 collide clean", rv, 8'hC3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule